// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block is the transmit half of a network controller's DMA path. Software builds a ring of two-word descriptors in memory. Each descriptor holds a buffer byte address in its first word and a status word in its second. Software then pulses a start strobe. The engine walks the ring from the queue base pointer and reads each referenced buffer through a word-wide memory port. It hands the bytes, in ascending address order, to a byte-wide transmit interface, and it flags the final byte of each frame.

When a frame has been sent, the engine writes back the status word of the frame's first descriptor with the used bit set. It halts at the first descriptor it finds already marked used. Two faults are recorded in the same write-back and abort the frame:

- The ring runs out in the middle of a frame.
- The downstream side is starved once transmission has begun.

A descriptor flagged as the ring's last one sends the engine back to the queue base.

Top module: `tx_desc_dma`

## Requirements
- R1: A start pulse is acted on only when `tx_en` is high and the engine is idle. A pulse with `tx_en` low, or while `busy` is high, has no effect on the memory port, the byte stream or the descriptors.
- R2: After an accepted start, the first memory request is a read of the descriptor at `q_base`. A descriptor is two 32-bit words: the buffer byte address at offset 0 and the status word at offset 4. The next descriptor lies 8 bytes further on.
- R3: Status bits 10:0 give the buffer length in bytes. That many bytes are streamed from the buffer address upward, starting at any byte alignment, with byte lane 0 of a word at the lowest address.
- R4: `tx_last` is high only together with the final byte of a buffer whose status bit 15 (last buffer of frame) is set.
- R5: When a frame completes, the status word of its first descriptor is written back with bit 31 (used) set and every other bit as read. Later descriptors of the frame are not written.
- R6: A descriptor fetched at a frame boundary with bit 31 set stops the engine: `busy` falls, and nothing is written or sent.
- R7: After a descriptor with status bit 30 (wrap) has been handled, the next descriptor is fetched from `q_base`.
- R8: A descriptor with bit 31 set that is fetched inside a frame causes bits 31 and 27 to be written into the frame's first status word. It also pulses `tx_abort` and stops the engine.
- R9: Once a frame's first byte has been taken, if `tx_ready` is high with no byte on offer for `STARVE_LIM` consecutive cycles, bits 31 and 28 are written into the frame's first status word. `tx_abort` pulses and the engine stops without sending more of the frame.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.
- R11: Out of reset, `busy`, `mem_req`, `tx_valid` and `tx_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable; gates the start strobe |
| tx_start | input | 1 | One-cycle start strobe |
| q_base | input | AW | Byte address of the first ring descriptor |
| busy | output | 1 | Engine is walking the ring |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (status write-back) |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after a granted read |
| tx_valid | output | 1 | Byte on offer |
| tx_ready | input | 1 | Downstream takes a byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of frame |
| tx_abort | output | 1 | One-cycle pulse: frame abandoned |

## Verification
The checker assumes a word-aligned `q_base` that does not change at the cycle a start is accepted. It also assumes that read data arrives exactly one cycle after each granted read. The bench memory model honours the fixed latency on every granted read, and the bench only moves `q_base` while the engine is busy, which must have no effect. Grant is withheld only in the starvation scenario. Backpressure on `tx_ready` is applied in a toggling pattern, so that the hold rule is exercised on real stalls.

// File: rtl/txdma_pkg.sv
// Shared constants and state type for the transmit descriptor DMA engine.
// Assumes a 32-bit descriptor word; bit positions are fixed by the ring format.
package txdma_pkg;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 11;
    localparam int LAST_BIT  = 15;
    localparam int EXH_BIT   = 27;
    localparam int URUN_BIT  = 28;
    localparam int WRAP_BIT  = 30;
    localparam int USED_BIT  = 31;
    localparam int DESC_STEP = 8;
    localparam int STS_OFS   = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ADR,
        ST_WT_ADR,
        ST_RD_STS,
        ST_WT_STS,
        ST_RD_DAT,
        ST_WT_DAT,
        ST_SEND,
        ST_WRBK,
        ST_ADV
    } dma_state_e;
endpackage

// File: rtl/txdma_unpack.sv
// Word-to-byte unpacker: holds up to four bytes of one buffer word and
// presents them lowest lane first. Assumes load and pop never coincide.
module txdma_unpack #(
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [WW-1:0] ld_word,
    input  logic [1:0]    ld_lane,
    input  logic [2:0]    ld_n,
    input  logic          pop,
    output logic [7:0]    byte_o,
    output logic [2:0]    cnt_o
);
    logic [WW-1:0] sh_q;
    logic [2:0]    cnt_q;

    // Shift register and remaining-byte count for the current word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (ld) begin
            sh_q  <= ld_word >> (8 * ld_lane);
            cnt_q <= ld_n;
        end else if (pop) begin
            sh_q  <= sh_q >> 8;
            cnt_q <= cnt_q - 3'd1;
        end
    end

    assign byte_o = sh_q[7:0];
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/txdma_starve.sv
// Starvation monitor: once a frame is flowing, counts consecutive cycles
// where the consumer wants a byte and none is offered. Assumes flow drops
// when the frame ends or is abandoned.
module txdma_starve #(
    parameter int LIM = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flow,
    input  logic tx_valid,
    input  logic tx_ready,
    output logic starve
);
    localparam int CW = $clog2(LIM + 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;

    // Consecutive-starve counter with a sticky flag until flow ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !flow) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (tx_valid) begin
            cnt_q <= '0;
        end else if (tx_ready) begin
            if (cnt_q == CW'(LIM - 1)) pend_q <= 1'b1;
            else                        cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign starve = pend_q && flow;
endmodule

// File: rtl/txdma_seq.sv
// Ring sequencer: fetches descriptors, schedules buffer word reads, drives
// the byte handshake, and writes back status. Assumes read data is valid
// exactly one cycle after a granted read and that addresses fit in AW bits.
module txdma_seq
    import txdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tx_start,
    input  logic [AW-1:0]     q_base,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ld,
    output logic [1:0]        ld_lane,
    output logic [2:0]        ld_n,
    input  logic [2:0]        up_cnt,
    input  logic              tx_ready,
    input  logic              starve,
    output logic              flow,
    output logic              tx_valid,
    output logic              tx_last,
    output logic              tx_abort
);
    dma_state_e        state_q;
    logic [AW-1:0]     ptr_q, first_ptr_q, cur_addr_q;
    logic [WORD_W-1:0] first_sts_q;
    logic [LEN_W-1:0]  rem_q;
    logic              cur_last_q, cur_wrap_q;
    logic              open_q, flow_q, abort_q;
    logic [1:0]        err_q;   // [1] underrun, [0] exhaustion
    logic [2:0]        avail;
    logic              pop;

    assign avail = 3'd4 - {1'b0, cur_addr_q[1:0]};
    assign pop   = tx_valid && tx_ready;

    // Byte count taken from the next buffer word.
    always_comb begin
        if (rem_q < LEN_W'(avail)) ld_n = rem_q[2:0];
        else                       ld_n = avail;
    end

    assign ld      = (state_q == ST_WT_DAT);
    assign ld_lane = cur_addr_q[1:0];

    // Memory request decode per state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = first_sts_q;
        unique case (state_q)
            ST_RD_ADR: begin
                mem_req  = !starve;
                mem_addr = ptr_q;
            end
            ST_RD_STS: begin
                mem_req  = !starve;
                mem_addr = ptr_q + AW'(STS_OFS);
            end
            ST_RD_DAT: begin
                mem_req  = !starve;
                mem_addr = {cur_addr_q[AW-1:2], 2'b00};
            end
            ST_WRBK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = first_ptr_q + AW'(STS_OFS);
                mem_wdata = first_sts_q;
                mem_wdata[USED_BIT] = 1'b1;
                mem_wdata[URUN_BIT] = first_sts_q[URUN_BIT] | err_q[1];
                mem_wdata[EXH_BIT]  = first_sts_q[EXH_BIT]  | err_q[0];
            end
            default: ;
        endcase
    end

    assign tx_valid = (state_q == ST_SEND);
    assign tx_last  = tx_valid && cur_last_q && (rem_q == '0) && (up_cnt == 3'd1);
    assign busy     = (state_q != ST_IDLE);
    assign flow     = flow_q;
    assign tx_abort = abort_q;

    // Main ring walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ptr_q       <= '0;
            first_ptr_q <= '0;
            cur_addr_q  <= '0;
            first_sts_q <= '0;
            rem_q       <= '0;
            cur_last_q  <= 1'b0;
            cur_wrap_q  <= 1'b0;
            open_q      <= 1'b0;
            flow_q      <= 1'b0;
            abort_q     <= 1'b0;
            err_q       <= '0;
        end else begin
            abort_q <= 1'b0;
            if (pop) flow_q <= !tx_last;
            unique case (state_q)
                ST_IDLE: begin
                    if (tx_start && tx_en) begin
                        ptr_q   <= q_base;
                        open_q  <= 1'b0;
                        err_q   <= '0;
                        state_q <= ST_RD_ADR;
                    end
                end
                ST_RD_ADR: begin
                    if (starve) begin
                        err_q   <= 2'b10;
                        state_q <= ST_WRBK;
                    end else if (mem_gnt) begin
                        state_q <= ST_WT_ADR;
                    end
                end
                ST_WT_ADR: begin
                    cur_addr_q <= mem_rdata[AW-1:0];
                    state_q    <= ST_RD_STS;
                end
                ST_RD_STS: begin
                    if (starve) begin
                        err_q   <= 2'b10;
                        state_q <= ST_WRBK;
                    end else if (mem_gnt) begin
                        state_q <= ST_WT_STS;
                    end
                end
                ST_WT_STS: begin
                    rem_q      <= mem_rdata[LEN_W-1:0];
                    cur_last_q <= mem_rdata[LAST_BIT];
                    cur_wrap_q <= mem_rdata[WRAP_BIT];
                    if (mem_rdata[USED_BIT]) begin
                        if (open_q) begin
                            err_q   <= 2'b01;
                            state_q <= ST_WRBK;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        if (!open_q) begin
                            first_ptr_q <= ptr_q;
                            first_sts_q <= mem_rdata;
                            open_q      <= 1'b1;
                        end
                        if (mem_rdata[LEN_W-1:0] != '0)
                            state_q <= ST_RD_DAT;
                        else if (mem_rdata[LAST_BIT])
                            state_q <= ST_WRBK;
                        else
                            state_q <= ST_ADV;
                    end
                end
                ST_RD_DAT: begin
                    if (starve) begin
                        err_q   <= 2'b10;
                        state_q <= ST_WRBK;
                    end else if (mem_gnt) begin
                        state_q <= ST_WT_DAT;
                    end
                end
                ST_WT_DAT: begin
                    rem_q      <= rem_q - LEN_W'(ld_n);
                    cur_addr_q <= cur_addr_q + AW'(ld_n);
                    state_q    <= ST_SEND;
                end
                ST_SEND: begin
                    if (pop && up_cnt == 3'd1) begin
                        if (rem_q != '0)     state_q <= ST_RD_DAT;
                        else if (cur_last_q) state_q <= ST_WRBK;
                        else                 state_q <= ST_ADV;
                    end
                end
                ST_WRBK: begin
                    if (mem_gnt) begin
                        open_q  <= 1'b0;
                        flow_q  <= 1'b0;
                        abort_q <= |err_q;
                        state_q <= (|err_q) ? ST_IDLE : ST_ADV;
                    end
                end
                ST_ADV: begin
                    if (starve) begin
                        err_q   <= 2'b10;
                        state_q <= ST_WRBK;
                    end else begin
                        ptr_q   <= cur_wrap_q ? q_base : ptr_q + AW'(DESC_STEP);
                        state_q <= ST_RD_ADR;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tx_desc_dma.sv
// Transmit descriptor DMA engine top: joins the ring sequencer, the byte
// unpacker and the starvation monitor. Assumes a word-aligned queue base.
module tx_desc_dma
    import txdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int STARVE_LIM = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tx_start,
    input  logic [AW-1:0]     q_base,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_abort
);
    logic       ld, flow, starve;
    logic [1:0] ld_lane;
    logic [2:0] ld_n, up_cnt;

    txdma_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_start(tx_start),
        .q_base(q_base), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .ld(ld), .ld_lane(ld_lane), .ld_n(ld_n), .up_cnt(up_cnt),
        .tx_ready(tx_ready), .starve(starve), .flow(flow),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_abort(tx_abort)
    );

    txdma_unpack #(.WW(WORD_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_word(mem_rdata),
        .ld_lane(ld_lane), .ld_n(ld_n), .pop(tx_valid && tx_ready),
        .byte_o(tx_data), .cnt_o(up_cnt)
    );

    txdma_starve #(.LIM(STARVE_LIM)) u_starve (
        .clk(clk), .rst_n(rst_n), .flow(flow), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .starve(starve)
    );
endmodule

// File: rtl/txdma_chk.sv
// Property checker for the transmit descriptor DMA engine, bound to the top.
// Assumes a word-aligned q_base held stable at the cycle a start is accepted.
module txdma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] q_base,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          tx_abort
);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !tx_valid));

    a_r2_base_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we && mem_addr == $past(q_base)));

    a_r4_last_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    a_r5_wb_used: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[31]);

    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (!tx_valid && !busy));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind tx_desc_dma txdma_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .q_base(q_base), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_abort(tx_abort)
);

// File: tb/tx_desc_dma_tb_top.sv
`timescale 1ns/1ps
module tx_desc_dma_tb_top;
    localparam int AW = 32;
    localparam int LIM = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0, tx_start = 1'b0;
    logic [AW-1:0] q_base = '0;
    logic          busy, mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          tx_valid, tx_ready, tx_last, tx_abort;
    logic [7:0]    tx_data;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    tx_desc_dma #(.AW(AW), .STARVE_LIM(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_start(tx_start),
        .q_base(q_base), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .tx_abort(tx_abort)
    );

    // Memory model: 256 words, fixed one-cycle read latency.
    logic [31:0] mem [256];
    logic        gnt_en = 1'b1;
    logic        bw_en = 1'b0;
    logic [7:0]  bw_a = '0;
    logic [31:0] bw_d = '0;
    assign mem_gnt = gnt_en;

    always @(posedge clk) begin
        if (bw_en) mem[bw_a] <= bw_d;
        else if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    // Consumer model and byte capture.
    int   rdy_mode = 1;  // 0 never, 1 always, 2 toggle
    logic rx_clr = 1'b0;
    logic [7:0] rx_d [64];
    logic       rx_l [64];
    int   rx_n = 0, ab_n = 0;

    initial tx_ready = 1'b0;
    always @(negedge clk) begin
        case (rdy_mode)
            0: tx_ready <= 1'b0;
            2: tx_ready <= ~tx_ready;
            default: tx_ready <= 1'b1;
        endcase
    end

    always @(posedge clk) begin
        if (rx_clr) begin
            rx_n <= 0;
            ab_n <= 0;
        end else begin
            if (tx_valid && tx_ready && rx_n < 64) begin
                rx_d[rx_n] <= tx_data;
                rx_l[rx_n] <= tx_last;
                rx_n <= rx_n + 1;
            end
            if (tx_abort) ab_n <= ab_n + 1;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic poke(input int byte_addr, input logic [31:0] d);
        @(negedge clk);
        bw_en = 1'b1; bw_a = 8'(byte_addr >> 2); bw_d = d;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic clr_rx();
        @(negedge clk); rx_clr = 1'b1;
        @(negedge clk); rx_clr = 1'b0;
    endtask

    task automatic kick(input int base);
        @(negedge clk);
        q_base = AW'(base); tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while (busy && t < 2000) begin
            @(negedge clk); t++;
        end
        repeat (3) @(negedge clk);
    endtask

    // Compare captured bytes against buffer pattern, last flag only at end.
    task automatic check_bytes(input string req, input int start_idx, input int a0, input int n, input logic last_at_end);
        for (int i = 0; i < n; i++) begin
            chk(rx_d[start_idx+i] == pat(a0 + i), req, 32'(rx_d[start_idx+i]), 32'(pat(a0 + i)));
            chk(rx_l[start_idx+i] == ((i == n - 1) && last_at_end), "R4",
                32'(rx_l[start_idx+i]), 32'((i == n - 1) && last_at_end));
        end
    endtask

    task automatic t_reset();
        chk(!busy && !mem_req && !tx_valid && !tx_abort, "R11",
            {28'd0, busy, mem_req, tx_valid, tx_abort}, 32'd0);
    endtask

    task automatic t_single();
        poke(32'h000, 32'h203);
        poke(32'h004, 32'h0000_8005);
        poke(32'h008, 32'h0);
        poke(32'h00C, 32'h8000_0000);
        clr_rx();
        kick(32'h000);
        wait_idle();
        chk(rx_n == 5, "R3", 32'(rx_n), 32'd5);
        check_bytes("R3", 0, 32'h203, 5, 1'b1);
        chk(mem[1] == 32'h8000_8005, "R5", mem[1], 32'h8000_8005);
        chk(mem[3] == 32'h8000_0000 && !busy, "R6", mem[3], 32'h8000_0000);
        chk(ab_n == 0, "R6", 32'(ab_n), 0);
    endtask

    task automatic t_multi_busy_start();
        poke(32'h040, 32'h222);
        poke(32'h044, 32'h0000_0003);
        poke(32'h048, 32'h241);
        poke(32'h04C, 32'h0000_8006);
        poke(32'h054, 32'h8000_0000);
        clr_rx();
        rdy_mode = 2;
        kick(32'h040);
        repeat (6) @(negedge clk);
        kick(32'h000);  // R1: ignored while busy
        q_base = 32'h040;
        wait_idle();
        rdy_mode = 1;
        chk(rx_n == 9, "R1", 32'(rx_n), 32'd9);
        check_bytes("R3", 0, 32'h222, 3, 1'b0);
        check_bytes("R3", 3, 32'h241, 6, 1'b1);
        chk(mem[32'h44 >> 2] == 32'h8000_0003, "R5", mem[32'h44 >> 2], 32'h8000_0003);
        chk(mem[32'h4C >> 2] == 32'h0000_8006, "R5", mem[32'h4C >> 2], 32'h0000_8006);
    endtask

    task automatic t_wrap();
        poke(32'h080, 32'h300);
        poke(32'h084, 32'h0000_8002);
        poke(32'h088, 32'h310);
        poke(32'h08C, 32'h4000_8003);
        poke(32'h090, 32'h3F0);          // trap beyond the ring end
        poke(32'h094, 32'h0000_8004);
        clr_rx();
        kick(32'h080);
        wait_idle();
        chk(rx_n == 5, "R7", 32'(rx_n), 32'd5);
        check_bytes("R7", 0, 32'h300, 2, 1'b1);
        check_bytes("R7", 2, 32'h310, 3, 1'b1);
        chk(mem[32'h8C >> 2] == 32'hC000_8003, "R7", mem[32'h8C >> 2], 32'hC000_8003);
        chk(mem[32'h94 >> 2] == 32'h0000_8004, "R7", mem[32'h94 >> 2], 32'h0000_8004);
    endtask

    task automatic t_disabled();
        poke(32'h0F0, 32'h2F0);
        poke(32'h0F4, 32'h0000_8002);
        poke(32'h0FC, 32'h8000_0000);
        clr_rx();
        tx_en = 1'b0;
        kick(32'h0F0);
        repeat (10) @(negedge clk);
        chk(!busy && rx_n == 0, "R1", {31'd0, busy}, 0);
        chk(mem[32'hF4 >> 2] == 32'h0000_8002, "R1", mem[32'hF4 >> 2], 32'h0000_8002);
        tx_en = 1'b1;
        kick(32'h0F0);
        wait_idle();
        chk(rx_n == 2, "R1", 32'(rx_n), 32'd2);
    endtask

    task automatic t_exhaust();
        poke(32'h0C0, 32'h260);
        poke(32'h0C4, 32'h0000_0004);
        poke(32'h0CC, 32'h8000_0000);
        clr_rx();
        kick(32'h0C0);
        wait_idle();
        chk(rx_n == 4, "R8", 32'(rx_n), 32'd4);
        check_bytes("R8", 0, 32'h260, 4, 1'b0);
        chk(mem[32'hC4 >> 2] == 32'h8800_0004, "R8", mem[32'hC4 >> 2], 32'h8800_0004);
        chk(ab_n == 1 && !busy, "R8", 32'(ab_n), 1);
    endtask

    task automatic t_underrun();
        int t = 0;
        poke(32'h0E0, 32'h280);
        poke(32'h0E4, 32'h0000_800A);
        poke(32'h0EC, 32'h8000_0000);
        clr_rx();
        kick(32'h0E0);
        while (rx_n < 1 && t < 200) begin
            @(negedge clk); t++;
        end
        gnt_en = 1'b0;
        repeat (40) @(negedge clk);
        gnt_en = 1'b1;
        wait_idle();
        chk(rx_n == 4, "R9", 32'(rx_n), 32'd4);
        check_bytes("R9", 0, 32'h280, 4, 1'b0);
        chk(mem[32'hE4 >> 2] == 32'h9000_800A, "R9", mem[32'hE4 >> 2], 32'h9000_800A);
        chk(ab_n == 1 && !busy, "R9", 32'(ab_n), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int w = 0; w < 256; w++)
            poke(w * 4, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
        tx_en = 1'b1;
        t_single();
        t_multi_busy_start();   // R10 exercised under toggling ready
        t_wrap();
        t_disabled();
        t_exhaust();
        t_underrun();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule